// File: doc/BRIEF.md
# Two-Stage Microprogrammed Execution Engine

This block is a small execution engine that runs a fixed microprogram held in a read-only control store of 32-bit microwords. Each microword spends two cycles in a two-stage pipeline, and one microword finishes every cycle. In the first stage the microword is decoded and two source fields pick any two registers. Their values, or one register and a zero-extended immediate, are captured in the two ALU operand latches. In the second stage the ALU works on the latched pair and a one-bit shifter follows it. In the same cycle, separate fields of the microword decide whether the result is written back, whether the condition flags or the event counter are updated, and whether a branch condition on the result redirects the microaddress.

The control store is split into equal sectors that are selected by the upper microaddress bits. It is read synchronously from the next microaddress, so the fetched word lines up with the microaddress register. A result that the second stage is writing is forwarded to a first-stage read of the same register. A taken branch discards the single microword that was fetched behind it. The register file, the flags, the counter and the microaddress are all visible at the outputs.

Top module: `useq_core`

## Requirements
- R1: While reset is high, the microaddress, all registers, the flags and the counter read zero. The first microword after reset comes from address 0.
- R2: With no branch, the microaddress goes up by one each cycle. A microword at address a that writes a register shows its result on the outputs after the (a+2)th rising edge following reset release.
- R3: Tag 00 (bits [31:30]) is the register format. The destination is in [29:26], the ALU code in [25:23], source A in [15:12] and source B in [11:8]. ALU codes: 0 passes A, 1 adds, 2 subtracts B from A, 3 ANDs, 4 ORs, 5 XORs.
- R4: Tag 01 is the immediate format. It has the same fields, except that operand B is bits [11:0] zero-extended.
- R5: The shift field [22:21] selects the shift applied to the ALU output. 00 means no shift, 01 shifts left by one bit with a zero entering, and 10 shifts right by one bit with a zero entering.
- R6: When stage one reads the register that stage two writes in the same cycle, stage one receives the new value.
- R7: Bit [18] set loads flags {C,N,Z} (flags_o[2:0]). Z means the shifted result is zero, N is its top bit, and C is the carry out of an add or the borrow of a subtract (0 for other codes). Bit [19] set increments the counter. Otherwise both keep their value.
- R8: Tag 10 is the branch format. It holds the condition in [29:27], the target in [26:16], the sources in [15:12] and [11:8], and the ALU code in [7:5]. Conditions: 0 never, 1 always, 2 zero, 3 nonzero, 4 negative, 5 non-negative, 6 carry, 7 no carry. They are evaluated on the branch's own ALU result. A branch writes no register, flag or counter.
- R9: A taken branch sets the microaddress to the target one edge after it resolves. The microword fetched behind it has no effect.
- R10: An untaken branch lets the following microword execute normally.
- R11: When the write-enable bit [20] is clear, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upc_o | output | log2(CS_DEPTH) | Current microaddress |
| flags_o | output | 3 | Condition flags {C,N,Z} |
| count_o | output | CW | Event counter |
| regs_o | output | 16*DW | Register file contents, register i at bits [i*DW +: DW] |

## Verification
The bench builds the block with a 64-word control store split into four 16-word sectors. This puts the sector switch inside a short microprogram: the closing loop jumps back and forth across a sector boundary. It keeps the 16-bit data path and an 8-bit counter, so borrow, negative and carry-out results show up with small operands. A fixed microprogram is passed in as the control-store image. It covers forwarded operands, every shift mode, taken and untaken branches with squashed followers, and a counted loop.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;

  localparam int NREG = 16;
  localparam int RAW  = 4;
  localparam int TGTW = 11;
  localparam int IMMW = 12;

  typedef enum logic [1:0] {
    FMT_REG = 2'b00,
    FMT_IMM = 2'b01,
    FMT_BR  = 2'b10,
    FMT_RSV = 2'b11
  } fmt_e;

  typedef enum logic [2:0] {
    OP_PASSA = 3'd0,
    OP_ADD   = 3'd1,
    OP_SUB   = 3'd2,
    OP_AND   = 3'd3,
    OP_OR    = 3'd4,
    OP_XOR   = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } aluop_e;

  typedef enum logic [1:0] {
    SH_NONE  = 2'd0,
    SH_LEFT  = 2'd1,
    SH_RIGHT = 2'd2,
    SH_RSV   = 2'd3
  } shift_e;

  typedef enum logic [2:0] {
    CC_NEVER  = 3'd0,
    CC_ALWAYS = 3'd1,
    CC_ZERO   = 3'd2,
    CC_NZERO  = 3'd3,
    CC_NEG    = 3'd4,
    CC_NNEG   = 3'd5,
    CC_CARRY  = 3'd6,
    CC_NCARRY = 3'd7
  } cond_e;

  typedef struct packed {
    logic            br;
    logic            imm;
    logic            wen;
    logic            set_fl;
    logic            bump;
    logic [RAW-1:0]  dst;
    aluop_e          op;
    shift_e          sh;
    cond_e           cc;
    logic [TGTW-1:0] tgt;
  } uctl_t;

  // Field extraction shared by every format; branch words never write.
  function automatic uctl_t decode(input logic [31:0] w);
    uctl_t c;
    c.br     = (fmt_e'(w[31:30]) == FMT_BR);
    c.imm    = (fmt_e'(w[31:30]) == FMT_IMM);
    c.dst    = w[29:26];
    if (c.br) begin
      c.op     = aluop_e'(w[7:5]);
      c.sh     = SH_NONE;
      c.wen    = 1'b0;
      c.set_fl = 1'b0;
      c.bump   = 1'b0;
      c.cc     = cond_e'(w[29:27]);
      c.tgt    = w[26:16];
    end else begin
      c.op     = aluop_e'(w[25:23]);
      c.sh     = shift_e'(w[22:21]);
      c.wen    = w[20];
      c.bump   = w[19];
      c.set_fl = w[18];
      c.cc     = CC_NEVER;
      c.tgt    = '0;
    end
    return c;
  endfunction

endpackage

// File: rtl/useq_cstore.sv
`timescale 1ns/1ps
module useq_cstore #(
  parameter int DEPTH        = 2048,
  parameter int SECTOR_WORDS = 512,
  parameter logic [DEPTH*32-1:0] INIT = '0,
  localparam int AW    = $clog2(DEPTH),
  localparam int SAW   = $clog2(SECTOR_WORDS),
  localparam int NSECT = DEPTH / SECTOR_WORDS,
  localparam int SELW  = (NSECT > 1) ? $clog2(NSECT) : 1
)(
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [31:0]   data
);

  logic [31:0]     sect_q [NSECT];
  logic [SELW-1:0] sel_q;

  // One synchronous-read ROM bank per sector.
  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    logic [31:0] mem [SECTOR_WORDS];
    logic [31:0] q;

    initial begin
      for (int i = 0; i < SECTOR_WORDS; i++)
        mem[i] = INIT[(s*SECTOR_WORDS + i)*32 +: 32];
    end

    always_ff @(posedge clk) q <= mem[addr[SAW-1:0]];

    assign sect_q[s] = q;
  end

  always_ff @(posedge clk) sel_q <= SELW'(addr >> SAW);

  assign data = sect_q[sel_q];

endmodule

// File: rtl/useq_regfile.sv
`timescale 1ns/1ps
module useq_regfile import useq_pkg::*; #(
  parameter int DW = 16
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [RAW-1:0]     waddr,
  input  logic [DW-1:0]      wdata,
  input  logic [RAW-1:0]     ra_a,
  input  logic [RAW-1:0]     ra_b,
  output logic [DW-1:0]      rd_a,
  output logic [DW-1:0]      rd_b,
  output logic [NREG*DW-1:0] state
);

  logic [DW-1:0] rf [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (we) begin
      rf[waddr] <= wdata;
    end
  end

  // Same-cycle write is bypassed to the readers.
  assign rd_a = (we && waddr == ra_a) ? wdata : rf[ra_a];
  assign rd_b = (we && waddr == ra_b) ? wdata : rf[ra_b];

  for (genvar g = 0; g < NREG; g++) begin : g_state
    assign state[g*DW +: DW] = rf[g];
  end

endmodule

// File: rtl/useq_alu.sv
`timescale 1ns/1ps
module useq_alu import useq_pkg::*; #(
  parameter int DW = 16
)(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  aluop_e        op,
  input  shift_e        sh,
  output logic [DW-1:0] y,
  output logic [2:0]    fl
);

  logic [DW:0]   wide;
  logic [DW-1:0] raw;
  logic          cy;

  always_comb begin
    wide = '0;
    raw  = a;
    cy   = 1'b0;
    case (op)
      OP_ADD: begin
        wide = {1'b0, a} + {1'b0, b};
        raw  = wide[DW-1:0];
        cy   = wide[DW];
      end
      OP_SUB: begin
        wide = {1'b0, a} - {1'b0, b};
        raw  = wide[DW-1:0];
        cy   = wide[DW];
      end
      OP_AND:  raw = a & b;
      OP_OR:   raw = a | b;
      OP_XOR:  raw = a ^ b;
      default: raw = a;
    endcase
  end

  always_comb begin
    case (sh)
      SH_LEFT:  y = {raw[DW-2:0], 1'b0};
      SH_RIGHT: y = {1'b0, raw[DW-1:1]};
      default:  y = raw;
    endcase
  end

  assign fl = {cy, y[DW-1], (y == '0)};

endmodule

// File: rtl/useq_core.sv
`timescale 1ns/1ps
module useq_core import useq_pkg::*; #(
  parameter int DW           = 16,
  parameter int CS_DEPTH     = 2048,
  parameter int SECTOR_WORDS = 512,
  parameter int CW           = 8,
  parameter logic [CS_DEPTH*32-1:0] CS_INIT = '0,
  localparam int UAW = $clog2(CS_DEPTH)
)(
  input  logic               clk,
  input  logic               rst,
  output logic [UAW-1:0]     upc_o,
  output logic [2:0]         flags_o,
  output logic [CW-1:0]      count_o,
  output logic [NREG*DW-1:0] regs_o
);

  // Fetch and stage one
  logic [UAW-1:0]  upc_q, upc_nxt;
  logic [31:0]     iw;
  uctl_t           c1;
  logic [RAW-1:0]  sa1, sb1;
  logic [IMMW-1:0] imm1;
  logic [DW-1:0]   rd_a, rd_b;

  // Stage two
  logic          s2_v;
  uctl_t         c2;
  logic [DW-1:0] a2, b2;
  logic [DW-1:0] res2;
  logic [2:0]    fl2;
  logic          wb_en, flag_upd, cnt_upd, cc_hit, taken;
  logic [2:0]    flags_q;
  logic [CW-1:0] count_q;

  useq_cstore #(
    .DEPTH(CS_DEPTH), .SECTOR_WORDS(SECTOR_WORDS), .INIT(CS_INIT)
  ) u_cs (
    .clk(clk), .addr(upc_nxt), .data(iw)
  );

  assign c1   = decode(iw);
  assign sa1  = iw[15:12];
  assign sb1  = iw[11:8];
  assign imm1 = iw[IMMW-1:0];

  useq_regfile #(.DW(DW)) u_rf (
    .clk(clk), .rst(rst),
    .we(wb_en), .waddr(c2.dst), .wdata(res2),
    .ra_a(sa1), .ra_b(sb1),
    .rd_a(rd_a), .rd_b(rd_b),
    .state(regs_o)
  );

  useq_alu #(.DW(DW)) u_alu (
    .a(a2), .b(b2), .op(c2.op), .sh(c2.sh), .y(res2), .fl(fl2)
  );

  assign wb_en    = s2_v && c2.wen;
  assign flag_upd = s2_v && c2.set_fl;
  assign cnt_upd  = s2_v && c2.bump;

  always_comb begin
    case (c2.cc)
      CC_NEVER:  cc_hit = 1'b0;
      CC_ALWAYS: cc_hit = 1'b1;
      CC_ZERO:   cc_hit = fl2[0];
      CC_NZERO:  cc_hit = !fl2[0];
      CC_NEG:    cc_hit = fl2[1];
      CC_NNEG:   cc_hit = !fl2[1];
      CC_CARRY:  cc_hit = fl2[2];
      default:   cc_hit = !fl2[2];
    endcase
  end

  assign taken = s2_v && c2.br && cc_hit;

  always_comb begin
    if (rst)        upc_nxt = '0;
    else if (taken) upc_nxt = UAW'(c2.tgt);
    else            upc_nxt = upc_q + 1'b1;
  end

  // Control state
  always_ff @(posedge clk) begin
    if (rst) begin
      upc_q   <= '0;
      s2_v    <= 1'b0;
      flags_q <= '0;
      count_q <= '0;
    end else begin
      upc_q <= upc_nxt;
      s2_v  <= !taken;
      if (flag_upd) flags_q <= fl2;
      if (cnt_upd)  count_q <= count_q + 1'b1;
    end
  end

  // Operand latches; validity carried by s2_v
  always_ff @(posedge clk) begin
    c2 <= c1;
    a2 <= rd_a;
    b2 <= c1.imm ? DW'(imm1) : rd_b;
  end

  assign upc_o   = upc_q;
  assign flags_o = flags_q;
  assign count_o = count_q;

endmodule

// File: rtl/useq_core_chk.sv
`timescale 1ns/1ps
module useq_core_chk #(
  parameter int UAW  = 11,
  parameter int DW   = 16,
  parameter int CW   = 8,
  parameter int NREG = 16
)(
  input logic               clk,
  input logic               rst,
  input logic [UAW-1:0]     upc_o,
  input logic [2:0]         flags_o,
  input logic [CW-1:0]      count_o,
  input logic [NREG*DW-1:0] regs_o,
  input logic               taken,
  input logic [UAW-1:0]     tgt,
  input logic               s2_v,
  input logic               wb_en,
  input logic [3:0]         wb_addr,
  input logic [DW-1:0]      wb_data,
  input logic [3:0]         rd_sa,
  input logic [DW-1:0]      a2,
  input logic               flag_upd,
  input logic               cnt_upd
);

  // R1
  reset_upc_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> upc_o == '0);

  // R2
  seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
    !taken |=> upc_o == UAW'($past(upc_o) + 1'b1));

  // R6
  fwd_operand_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && wb_en && wb_addr == rd_sa) |-> a2 == $past(wb_data));

  // R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !flag_upd |=> $stable(flags_o));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_upd |=> count_o == CW'($past(count_o) + 1'b1));

  // R9
  squash_chk: assert property (@(posedge clk) disable iff (rst)
    taken |=> !s2_v);

  // R9
  redirect_chk: assert property (@(posedge clk) disable iff (rst)
    taken |=> upc_o == $past(tgt));

  // R11
  regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wb_en |=> $stable(regs_o));

endmodule

bind useq_core useq_core_chk #(
  .UAW(UAW), .DW(DW), .CW(CW), .NREG(NREG)
) u_chk (
  .clk(clk), .rst(rst), .upc_o(upc_o), .flags_o(flags_o),
  .count_o(count_o), .regs_o(regs_o), .taken(taken),
  .tgt(UAW'(c2.tgt)), .s2_v(s2_v), .wb_en(wb_en), .wb_addr(c2.dst),
  .wb_data(res2), .rd_sa(sa1), .a2(a2), .flag_upd(flag_upd),
  .cnt_upd(cnt_upd)
);

// File: tb/useq_core_test.sv
`timescale 1ns/1ps
module useq_core_test;

  localparam int DW    = 16;
  localparam int DEPTH = 64;
  localparam int SECT  = 16;
  localparam int CW    = 8;
  localparam int UAW   = $clog2(DEPTH);

  function automatic logic [31:0] rw(int d, int op, int sh, int we, int m, int a, int b);
    return {2'b00, 4'(d), 3'(op), 2'(sh), 1'(we), 2'(m), 2'b00, 4'(a), 4'(b), 8'h00};
  endfunction
  function automatic logic [31:0] iw(int d, int op, int sh, int we, int m, int a, int k);
    return {2'b01, 4'(d), 3'(op), 2'(sh), 1'(we), 2'(m), 2'b00, 4'(a), 12'(k)};
  endfunction
  function automatic logic [31:0] bw(int cc, int t, int a, int b, int op);
    return {2'b10, 3'(cc), 11'(t), 4'(a), 4'(b), 3'(op), 5'b00000};
  endfunction

  // misc field: 1 = load flags, 2 = bump counter
  function automatic logic [DEPTH*32-1:0] build_prog();
    logic [DEPTH*32-1:0] p = '0;
    p[ 0*32 +: 32] = iw(1, 1, 0, 1, 0, 0, 5);        // r1 = 5
    p[ 1*32 +: 32] = iw(2, 1, 0, 1, 0, 1, 3);        // r2 = r1 + 3 (forwarded)
    p[ 2*32 +: 32] = rw(3, 2, 0, 1, 1, 2, 1);        // r3 = r2 - r1, flags
    p[ 3*32 +: 32] = rw(4, 5, 1, 1, 0, 2, 1);        // r4 = (r2^r1)<<1
    p[ 4*32 +: 32] = rw(5, 3, 2, 1, 1, 2, 1);        // r5 = (r2&r1)>>1, flags
    p[ 5*32 +: 32] = rw(6, 4, 2, 1, 0, 1, 2);        // r6 = (r1|r2)>>1
    p[ 6*32 +: 32] = iw(7, 1, 0, 0, 2, 0, 12'hFFF);  // no write, count
    p[ 7*32 +: 32] = rw(8, 2, 0, 1, 1, 0, 1);        // r8 = 0 - r1, flags
    p[ 8*32 +: 32] = bw(4, 11, 8, 0, 0);             // if neg(r8) -> 11
    p[ 9*32 +: 32] = iw(9, 1, 0, 1, 0, 0, 12'h0AA);  // squashed
    p[10*32 +: 32] = iw(10, 1, 0, 1, 0, 0, 12'h0BB); // never fetched
    p[11*32 +: 32] = bw(2, 20, 1, 1, 3);             // if zero(r1&r1): no
    p[12*32 +: 32] = rw(11, 1, 0, 1, 2, 4, 6);       // r11 = r4 + r6, count
    p[13*32 +: 32] = bw(1, 15, 0, 0, 0);             // always -> 15
    p[14*32 +: 32] = iw(12, 1, 0, 1, 0, 0, 12'h0CC); // squashed
    p[15*32 +: 32] = iw(13, 1, 0, 1, 2, 13, 1);      // r13++, count
    p[16*32 +: 32] = bw(3, 15, 13, 2, 2);            // if r13 != r2 -> 15
    p[17*32 +: 32] = rw(14, 1, 0, 1, 1, 8, 1);       // r14 = r8 + r1, flags
    p[18*32 +: 32] = bw(1, 18, 0, 0, 0);             // park
    p[19*32 +: 32] = iw(15, 1, 0, 1, 0, 0, 12'h777); // always squashed
    return p;
  endfunction

  localparam logic [DEPTH*32-1:0] PROG = build_prog();

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [UAW-1:0]     upc_o;
  logic [2:0]         flags_o;
  logic [CW-1:0]      count_o;
  logic [16*DW-1:0]   regs_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  useq_core #(
    .DW(DW), .CS_DEPTH(DEPTH), .SECTOR_WORDS(SECT), .CW(CW), .CS_INIT(PROG)
  ) uut (
    .clk(clk), .rst(rst), .upc_o(upc_o), .flags_o(flags_o),
    .count_o(count_o), .regs_o(regs_o)
  );

  // {edge, kind(0 upc,1 reg,2 flags {C,N,Z},3 count), index, expected, req}
  localparam int NV = 35;
  localparam logic [33:0] VEC [NV] = '{
    {8'd1,  2'd0, 4'd0,  16'd1,      4'd2},   // R2
    {8'd2,  2'd1, 4'd1,  16'd5,      4'd4},   // R4
    {8'd3,  2'd1, 4'd2,  16'd8,      4'd6},   // R6
    {8'd4,  2'd1, 4'd3,  16'd3,      4'd3},   // R3
    {8'd5,  2'd2, 4'd0,  16'd0,      4'd7},   // R7
    {8'd5,  2'd1, 4'd4,  16'h001A,   4'd5},   // R5
    {8'd6,  2'd2, 4'd0,  16'd1,      4'd7},   // R7
    {8'd6,  2'd1, 4'd5,  16'd0,      4'd3},   // R3
    {8'd7,  2'd1, 4'd6,  16'd6,      4'd5},   // R5
    {8'd8,  2'd3, 4'd0,  16'd1,      4'd7},   // R7
    {8'd8,  2'd1, 4'd7,  16'd0,      4'd11},  // R11
    {8'd9,  2'd2, 4'd0,  16'd6,      4'd7},   // R7
    {8'd9,  2'd1, 4'd8,  16'hFFFB,   4'd3},   // R3
    {8'd9,  2'd0, 4'd0,  16'd9,      4'd2},   // R2
    {8'd10, 2'd0, 4'd0,  16'd11,     4'd9},   // R9
    {8'd11, 2'd0, 4'd0,  16'd12,     4'd10},  // R10
    {8'd13, 2'd1, 4'd11, 16'h0020,   4'd10},  // R10
    {8'd13, 2'd3, 4'd0,  16'd2,      4'd7},   // R7
    {8'd14, 2'd0, 4'd0,  16'd15,     4'd9},   // R9
    {8'd17, 2'd0, 4'd0,  16'd15,     4'd9},   // R9
    {8'd37, 2'd1, 4'd13, 16'd8,      4'd8},   // R8
    {8'd37, 2'd3, 4'd0,  16'd10,     4'd7},   // R7
    {8'd38, 2'd0, 4'd0,  16'd18,     4'd10},  // R10
    {8'd39, 2'd2, 4'd0,  16'd5,      4'd7},   // R7
    {8'd39, 2'd1, 4'd14, 16'd0,      4'd3},   // R3
    {8'd40, 2'd0, 4'd0,  16'd18,     4'd9},   // R9
    {8'd41, 2'd0, 4'd0,  16'd19,     4'd9},   // R9
    {8'd42, 2'd0, 4'd0,  16'd18,     4'd9},   // R9
    {8'd42, 2'd1, 4'd9,  16'd0,      4'd9},   // R9
    {8'd42, 2'd1, 4'd10, 16'd0,      4'd9},   // R9
    {8'd42, 2'd1, 4'd12, 16'd0,      4'd9},   // R9
    {8'd42, 2'd1, 4'd15, 16'd0,      4'd9},   // R9
    {8'd42, 2'd1, 4'd4,  16'h001A,   4'd8},   // R8
    {8'd42, 2'd1, 4'd6,  16'd6,      4'd8},   // R8
    {8'd42, 2'd1, 4'd0,  16'd0,      4'd8}    // R8
  };

  function automatic logic [15:0] probe(int kind, int idx);
    case (kind)
      0:       return 16'(upc_o);
      1:       return regs_o[idx*DW +: DW];
      2:       return 16'(flags_o);
      default: return 16'(count_o);
    endcase
  endfunction

  task automatic check(int req, logic [255:0] got, logic [255:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int e;
    // R1: state while reset is held
    repeat (3) @(posedge clk);
    #2;
    check(1, 256'(upc_o), 256'(0));
    check(1, 256'(regs_o), 256'(0));
    check(1, 256'({flags_o, count_o}), 256'(0));
    @(negedge clk);
    rst = 1'b0;

    e = 0;
    for (int k = 0; k < NV; k++) begin
      int ed, kind, idx, req;
      logic [15:0] exp;
      {ed, kind, idx, exp, req} = {24'd0, VEC[k][33:26], 30'd0, VEC[k][25:24],
                                   28'd0, VEC[k][23:20], VEC[k][19:4],
                                   28'd0, VEC[k][3:0]};
      while (e < ed) begin
        @(posedge clk);
        #2;
        e++;
      end
      check(req, 256'(probe(kind, idx)), 256'(exp));
    end

    // R1: reset in mid-run clears everything and restarts at address 0
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check(1, 256'(upc_o), 256'(0));
    check(1, 256'(regs_o), 256'(0));
    check(1, 256'(count_o), 256'(0));
    check(1, 256'(flags_o), 256'(0));
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #2;
    check(1, 256'(upc_o), 256'(1));
    @(posedge clk);
    #2;
    check(1, 256'(regs_o[1*DW +: DW]), 256'(5));

    finish_run();
  end

endmodule